// File: doc/BRIEF.md
# LIN Slave Baud Divider Update Control

This block owns the active baud-rate divider of a LIN slave receiver and decides in which cycle a divider value written by software becomes active. Software writes a prescaler field and a fractional field into a shadow copy. Software also writes a deferral control bit. Without deferral, a prescaler write moves the whole shadow copy into the active divider at once. With deferral armed in slave mode, the copy waits for the receiver's data-ready strobe. That strobe marks the next received character, and the deferral bit then clears itself.

An auto-synchronisation unit may load a measured divider at any time. Its load always wins over a software-driven update in the same cycle. Baud generation, receive framing and the synchronisation measurement lie outside this block. The block only holds and commits the divider value.

Top module: `lin_div_update`

## Requirements
- R1: After reset, `div_o` is 0 (generator stopped) and `defer_o` is 0.
- R2: When deferral is inactive, a prescaler write makes `div_o` equal, from the next cycle, to the written prescaler in bits [15:4] and the shadow fraction in bits [3:0]. The shadow fraction is the one written in the same cycle if there is one. Deferral is inactive when `defer_o`=0 or `lin_slave_i`=0.
- R3: A fraction write alone (`wr_frac_i`, value in `wr_data_i[3:0]`) updates only the shadow copy and leaves `div_o` unchanged. That fraction becomes active together with the next committed prescaler.
- R4: With `lin_slave_i`=1 and `defer_o`=1, a prescaler write leaves `div_o` unchanged. The next `rx_ready_i` strobe loads the whole shadow copy into `div_o`.
- R5: `rx_ready_i` clears `defer_o` in the next cycle, and this hardware clear wins over a same-cycle control write. Otherwise a control write (`wr_ctrl_i`) sets `defer_o` to `wr_defer_i`.
- R6: If deferral is armed and no write arrives before `rx_ready_i`, the strobe reloads the unchanged shadow copy, so `div_o` keeps its value.
- R7: A prescaler write in the same cycle as `rx_ready_i` with deferral armed commits the newly written value.
- R8: `asu_load_i` loads `asu_div_i` into both `div_o` and the shadow copy in the next cycle. Any software write or strobe-driven commit in that cycle is discarded.
- R9: With `lin_slave_i`=0, the deferral bit has no effect and prescaler writes take effect immediately.
- R10: `rx_ready_i` with deferral inactive leaves `div_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_slave_i | input | 1 | LIN slave mode selected |
| wr_prsc_i | input | 1 | Write strobe for the prescaler field |
| wr_frac_i | input | 1 | Write strobe for the fraction field |
| wr_data_i | input | 12 | Write data; fraction uses bits [3:0] |
| wr_ctrl_i | input | 1 | Write strobe for the deferral bit |
| wr_defer_i | input | 1 | Deferral bit value to write |
| rx_ready_i | input | 1 | Receive data-ready strobe |
| asu_load_i | input | 1 | Auto-synch load request |
| asu_div_i | input | 16 | Auto-synch divider value |
| div_o | output | 16 | Active divider {prescaler, fraction} |
| defer_o | output | 1 | Current deferral bit |

## Verification
The bench builds the block with its default widths: a 12-bit prescaler and a 4-bit fraction. This puts the all-ones prescaler and the field boundary at bit 4 within reach of directed writes. A randomised phase drives overlapping writes, strobes and auto-synch loads across both modes. It reaches the priority corners: a load against a write, a strobe against a control write, and a write in the same cycle as a strobe. These are compared each cycle with a behavioural model.

// File: rtl/lin_div_pkg.sv
package lin_div_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ASU  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_RX   = 2'd3
  } commit_src_e;
endpackage

// File: rtl/lin_div_shadow.sv
module lin_div_shadow #(
  parameter int PRSC_W = 12,
  parameter int FRAC_W = 4,
  localparam int DW = PRSC_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_prsc_i,
  input  logic              wr_frac_i,
  input  logic [PRSC_W-1:0] wr_data_i,
  input  logic              asu_load_i,
  input  logic [DW-1:0]     asu_div_i,
  output logic [DW-1:0]     sh_next_o
);
  logic [PRSC_W-1:0] prsc_q;
  logic [FRAC_W-1:0] frac_q;
  logic [PRSC_W-1:0] prsc_d;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    prsc_d = wr_prsc_i ? wr_data_i : prsc_q;
    frac_d = wr_frac_i ? wr_data_i[FRAC_W-1:0] : frac_q;
    if (asu_load_i) begin
      prsc_d = asu_div_i[DW-1:FRAC_W];
      frac_d = asu_div_i[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prsc_q <= '0;
      frac_q <= '0;
    end else begin
      prsc_q <= prsc_d;
      frac_q <= frac_d;
    end
  end

  assign sh_next_o = {prsc_d, frac_d};
endmodule

// File: rtl/lin_div_mode.sv
module lin_div_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ctrl_i,
  input  logic wr_defer_i,
  input  logic rx_ready_i,
  output logic defer_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         defer_o <= 1'b0;
    else if (rx_ready_i) defer_o <= 1'b0;  // hw clear wins
    else if (wr_ctrl_i)  defer_o <= wr_defer_i;
  end
endmodule

// File: rtl/lin_div_arbiter.sv
module lin_div_arbiter
  import lin_div_pkg::*;
(
  input  logic        asu_load_i,
  input  logic        wr_prsc_i,
  input  logic        rx_ready_i,
  input  logic        deferred_i,
  output commit_src_e src_o
);
  always_comb begin
    src_o = SRC_NONE;
    if (asu_load_i)                    src_o = SRC_ASU;
    else if (deferred_i && rx_ready_i) src_o = SRC_RX;
    else if (!deferred_i && wr_prsc_i) src_o = SRC_SW;
  end
endmodule

// File: rtl/lin_div_active.sv
module lin_div_active
  import lin_div_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  commit_src_e src_i,
  input  logic [DW-1:0] asu_div_i,
  input  logic [DW-1:0] sh_next_i,
  output logic [DW-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_o <= '0;
    else begin
      unique case (src_i)
        SRC_ASU:        div_o <= asu_div_i;
        SRC_SW, SRC_RX: div_o <= sh_next_i;
        default:        div_o <= div_o;
      endcase
    end
  end
endmodule

// File: rtl/lin_div_update.sv
module lin_div_update
  import lin_div_pkg::*;
#(
  parameter int PRSC_W = 12,
  parameter int FRAC_W = 4,
  localparam int DW = PRSC_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lin_slave_i,
  input  logic              wr_prsc_i,
  input  logic              wr_frac_i,
  input  logic [PRSC_W-1:0] wr_data_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_defer_i,
  input  logic              rx_ready_i,
  input  logic              asu_load_i,
  input  logic [DW-1:0]     asu_div_i,
  output logic [DW-1:0]     div_o,
  output logic              defer_o
);
  logic [DW-1:0] sh_next;
  commit_src_e   src;
  logic          deferred;

  assign deferred = lin_slave_i & defer_o;

  lin_div_shadow #(.PRSC_W(PRSC_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk_i, .rst_ni, .wr_prsc_i, .wr_frac_i, .wr_data_i,
    .asu_load_i, .asu_div_i, .sh_next_o(sh_next)
  );

  lin_div_mode u_mode (
    .clk_i, .rst_ni, .wr_ctrl_i, .wr_defer_i, .rx_ready_i, .defer_o
  );

  lin_div_arbiter u_arb (
    .asu_load_i, .wr_prsc_i, .rx_ready_i, .deferred_i(deferred), .src_o(src)
  );

  lin_div_active #(.DW(DW)) u_active (
    .clk_i, .rst_ni, .src_i(src), .asu_div_i, .sh_next_i(sh_next), .div_o
  );
endmodule

// File: rtl/lin_div_update_chk.sv
module lin_div_update_chk #(
  parameter int PRSC_W = 12,
  parameter int FRAC_W = 4,
  localparam int DW = PRSC_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lin_slave_i,
  input logic              wr_prsc_i,
  input logic              wr_frac_i,
  input logic [PRSC_W-1:0] wr_data_i,
  input logic              wr_ctrl_i,
  input logic              wr_defer_i,
  input logic              rx_ready_i,
  input logic              asu_load_i,
  input logic [DW-1:0]     asu_div_i,
  input logic [DW-1:0]     div_o,
  input logic              defer_o
);
  // R8
  asu_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asu_load_i |=> div_o == $past(asu_div_i));
  // R5
  hw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i |=> !defer_o);
  // R2
  imm_prsc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prsc_i && !asu_load_i && !(lin_slave_i && defer_o))
      |=> div_o[DW-1:FRAC_W] == $past(wr_data_i));
  // R4
  defer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_slave_i && defer_o && !rx_ready_i && !asu_load_i) |=> $stable(div_o));
  // R3
  frac_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_prsc_i && !rx_ready_i && !asu_load_i) |=> $stable(div_o));
  // R10
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_i && !wr_prsc_i && !asu_load_i && !(lin_slave_i && defer_o))
      |=> $stable(div_o));
endmodule

bind lin_div_update lin_div_update_chk #(.PRSC_W(PRSC_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/tb_lin_div_update.sv
module tb_lin_div_update;
  localparam int PW = 12;
  localparam int FW = 4;
  localparam int DW = PW + FW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lin_slave_i = 0, wr_prsc_i = 0, wr_frac_i = 0, wr_ctrl_i = 0, wr_defer_i = 0;
  logic rx_ready_i = 0, asu_load_i = 0;
  logic [PW-1:0] wr_data_i = '0;
  logic [DW-1:0] asu_div_i = '0;
  logic [DW-1:0] div_o;
  logic defer_o;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_sp, m_sf, m_div, m_def;

  always #5 clk_i = ~clk_i;

  lin_div_update #(.PRSC_W(PW), .FRAC_W(FW)) dut (.*);

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sp = 0; m_sf = 0; m_div = 0; m_def = 0;
    end else begin
      int np, nf;
      bit armed;
      armed = lin_slave_i && (m_def != 0);
      np = wr_prsc_i ? int'(wr_data_i) : m_sp;
      nf = wr_frac_i ? int'(wr_data_i) % 16 : m_sf;
      if (asu_load_i) begin
        m_div = int'(asu_div_i);
        m_sp = m_div / 16;
        m_sf = m_div % 16;
      end else begin
        m_sp = np; m_sf = nf;
        if ((armed && rx_ready_i) || (!armed && wr_prsc_i)) m_div = np * 16 + nf;
      end
      if (rx_ready_i) m_def = 0;
      else if (wr_ctrl_i) m_def = wr_defer_i ? 1 : 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare model every clock
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk({cur_req, " div"}, int'(div_o), m_div);
    chk({cur_req, " defer"}, int'(defer_o), m_def);
  end

  task automatic drv(bit wp, bit wf, int d, bit wc, bit wd, bit rx, bit al, int ad);
    wr_prsc_i = wp; wr_frac_i = wf; wr_data_i = PW'(d);
    wr_ctrl_i = wc; wr_defer_i = wd; rx_ready_i = rx;
    asu_load_i = al; asu_div_i = DW'(ad);
    @(negedge clk_i);
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset div", int'(div_o), 0);
    chk("R1 reset defer", int'(defer_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    cur_req = "R1"; idle();
    // R2 immediate
    cur_req = "R2"; lin_slave_i = 1;
    drv(1, 0, 'hABC, 0, 0, 0, 0, 0);
    chk("R2 direct", int'(div_o), 'hABC0);
    drv(1, 1, 'hFF5, 0, 0, 0, 0, 0);
    chk("R2 with frac", int'(div_o), 'hFF55);
    // R3 fraction alone
    cur_req = "R3";
    drv(0, 1, 'h009, 0, 0, 0, 0, 0);
    chk("R3 frac only", int'(div_o), 'hFF55);
    drv(1, 0, 'h123, 0, 0, 0, 0, 0);
    chk("R3 frac joins", int'(div_o), 'h1239);
    // R4 deferred
    cur_req = "R4";
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R4 armed", int'(defer_o), 1);
    drv(1, 0, 'h456, 0, 0, 0, 0, 0);
    chk("R4 held", int'(div_o), 'h1239);
    idle();
    cur_req = "R5";
    drv(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 commit", int'(div_o), 'h4569);
    chk("R5 cleared", int'(defer_o), 0);
    // R6 no write
    cur_req = "R6";
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 unchanged", int'(div_o), 'h4569);
    // R7 same cycle
    cur_req = "R7";
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    drv(1, 0, 'h777, 0, 0, 1, 0, 0);
    chk("R7 new value", int'(div_o), 'h7779);
    // R5 hw clear beats sw set
    cur_req = "R5";
    drv(0, 0, 0, 1, 1, 1, 0, 0);
    chk("R5 clear wins", int'(defer_o), 0);
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 sw clear", int'(defer_o), 0);
    // R8 asu priority
    cur_req = "R8";
    drv(1, 1, 'h321, 0, 0, 0, 1, 'hBEEF);
    chk("R8 asu wins", int'(div_o), 'hBEEF);
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 1, 1, 'h1111);
    chk("R8 asu over rx", int'(div_o), 'h1111);
    // R9 not slave
    cur_req = "R9"; lin_slave_i = 0;
    drv(0, 0, 0, 1, 1, 0, 0, 0);
    drv(1, 0, 'h0F0, 0, 0, 0, 0, 0);
    chk("R9 immediate", int'(div_o), 'h0F01);
    // R10
    cur_req = "R10"; lin_slave_i = 1;
    drv(0, 0, 0, 0, 0, 1, 0, 0);
    drv(1, 1, 'h00A, 0, 0, 0, 0, 0);
    drv(0, 1, 'h003, 0, 0, 1, 0, 0);
    chk("R10 no change", int'(div_o), 'h00AA);
    // mixed random
    cur_req = "R2,R4,R5,R8";
    for (int i = 0; i < 400; i++) begin
      lin_slave_i = ($urandom % 4) != 0;
      drv($urandom % 3 == 0, $urandom % 3 == 0, $urandom, $urandom % 4 == 0,
          $urandom % 2 == 0, $urandom % 4 == 0, $urandom % 8 == 0, $urandom);
    end
    idle();
    finish_run();
  end
endmodule